// File: doc/BRIEF.md
# Page-Wrapping Serial Memory Address Pointer

This block keeps the byte address used by a serial nonvolatile memory controller. The protocol engine loads a complete word address when the host supplies one. After that it asks for one step for each byte that moves across the bus. How a step advances the pointer depends on the direction of the current operation. A write keeps the pointer inside one page and wraps within it. A read walks the whole array and wraps from the top byte back to zero.

The pointer holds its value between transactions. A read that carries no address therefore starts one past the byte that was last touched. The block also presents the in-page part of the address as an index into a page-sized data buffer. Memory size and page size are compile-time parameters; both must be powers of two, and the page must fit inside the memory.

Top module: `eep_ptr_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pointer becomes zero after that edge.
- R2: When `ld_en` is high at an edge, `cur_addr` equals `ld_addr` after that edge.
- R3: When `ld_en` and `step` are both high at an edge, the load wins in either direction: `cur_addr` equals `ld_addr` after the edge.
- R4: A step with `rd_mode` = 0 (write) adds one to the low log2(PAGE_BYTES) bits modulo the page size and keeps the upper bits. From the last byte of a page the pointer returns to the first byte of the same page.
- R5: A step with `rd_mode` = 1 (read) adds one to the full address modulo MEM_BYTES, so MEM_BYTES-1 is followed by 0.
- R6: With neither `ld_en` nor `step` high, the pointer keeps its value over any number of cycles.
- R7: `page_idx` always equals the low log2(PAGE_BYTES) bits of `cur_addr`.
- R8: The address width is log2(MEM_BYTES). With the defaults (1024-byte memory, 16-byte pages) that gives a 10-bit address and a 4-bit page index.
- R9: `rd_mode` has no effect on the pointer when neither `ld_en` nor `step` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Load the pointer from `ld_addr` |
| ld_addr | input | ADDR_W | Full word address to load |
| step | input | 1 | Advance the pointer by one byte |
| rd_mode | input | 1 | 1 = read (full wrap), 0 = write (page wrap) |
| cur_addr | output | ADDR_W | Current byte address |
| page_idx | output | IDX_W | In-page offset for the page buffer |

## Verification
Two functions can fall in the same cycle: a load and a step. The bench raises `ld_en` and `step` together in both write and read direction. It loads values whose write-step or read-step result would differ from the loaded address, so only the load value can match. In the cycle after the edge, it judges that `cur_addr` and `page_idx` show the loaded address and not the stepped one.

// File: rtl/eep_ptr_pkg.sv
// Package: shared types and helpers for the address pointer.
// Assumes: callers pass positive sizes.
package eep_ptr_pkg;

    // Direction of the current transfer, as the protocol engine reports it.
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    // True when v is a nonzero power of two.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/eep_ptr_next.sv
// Module: eep_ptr_next
// Computes the address that follows cur for a single step, as pure logic.
// A read step counts the whole word and wraps at the top of the array.
// A write step counts only the in-page bits and leaves the page row unchanged.
// Assumes: IDX_W >= 1 and IDX_W <= ADDR_W.
module eep_ptr_next
    import eep_ptr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  dir_e              dir,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] rd_next;
    logic [ADDR_W-1:0] wr_next;
    logic [IDX_W-1:0]  low_inc;

    // Full-width increment; the carry out of the top bit is dropped.
    always_comb rd_next = cur + 1'b1;

    // Increment of the in-page offset alone, modulo the page size.
    always_comb low_inc = cur[IDX_W-1:0] + 1'b1;

    generate
        if (IDX_W == ADDR_W) begin : g_single_page
            // One page spans the whole memory; there are no row bits to keep.
            always_comb wr_next = low_inc;
        end else begin : g_multi_page
            // Keep the row bits and replace the offset.
            always_comb wr_next = {cur[ADDR_W-1:IDX_W], low_inc};
        end
    endgenerate

    // Choose the rule that matches the direction of the transfer.
    always_comb nxt = (dir == DIR_READ) ? rd_next : wr_next;

endmodule

// File: rtl/eep_ptr_reg.sv
// Module: eep_ptr_reg
// Pointer register with synchronous active-low reset.
// Priority: reset first, then load, then step; otherwise the value is held.
// Assumes: step_val is already the correct next address for a step.
module eep_ptr_reg #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step,
    input  logic [ADDR_W-1:0] step_val,
    output logic [ADDR_W-1:0] q
);

    // Update the stored address; it is retained whenever nothing is asked.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (ld_en) q <= ld_val;
        else if (step)  q <= step_val;
    end

endmodule

// File: rtl/eep_ptr_top.sv
// Module: eep_ptr_top
// Byte address pointer of a serial memory. A write step wraps within the
// current page; a read step wraps over the whole memory. The value is kept
// between transactions.
// Assumes: MEM_BYTES and PAGE_BYTES are powers of two and
//          2 <= PAGE_BYTES <= MEM_BYTES.
module eep_ptr_top
    import eep_ptr_pkg::*;
#(
    parameter  int MEM_BYTES  = 1024,
    parameter  int PAGE_BYTES = 16,
    localparam int ADDR_W     = $clog2(MEM_BYTES),
    localparam int IDX_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              step,
    input  logic              rd_mode,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [IDX_W-1:0]  page_idx
);

    // Reject parameter sets the pointer cannot serve.
    generate
        if (!is_pow2(MEM_BYTES) || !is_pow2(PAGE_BYTES) ||
            PAGE_BYTES < 2 || (MEM_BYTES % PAGE_BYTES) != 0) begin : g_bad_cfg
            $error("eep_ptr_top: page size must be a power of two >= 2 dividing the memory size");
        end
    endgenerate

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_step;
    dir_e              dir;

    // Map the mode pin onto the direction type.
    always_comb dir = rd_mode ? DIR_READ : DIR_WRITE;

    eep_ptr_next #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_next (
        .cur (ptr_q),
        .dir (dir),
        .nxt (ptr_step)
    );

    eep_ptr_reg #(
        .ADDR_W (ADDR_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_val   (ld_addr),
        .step     (step),
        .step_val (ptr_step),
        .q        (ptr_q)
    );

    // Drive the outputs straight from the register.
    always_comb cur_addr = ptr_q;
    always_comb page_idx = ptr_q[IDX_W-1:0];

endmodule

// File: rtl/eep_ptr_chk.sv
// Module: eep_ptr_chk
// Protocol checker for eep_ptr_top, attached with bind.
// Assumes: inputs are known whenever rst_n is high.
module eep_ptr_chk #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              step,
    input logic              rd_mode,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [IDX_W-1:0]  page_idx
);

    // R1: a reset edge clears the pointer
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);

    // R2, R3: a load wins over a step
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> cur_addr == $past(ld_addr));

    // R4: a write step keeps the page row
    a_r4_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && step && !rd_mode) |=>
            (cur_addr >> IDX_W) == ($past(cur_addr) >> IDX_W));

    // R4: a write step advances the offset modulo the page size
    a_r4_offset_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && step && !rd_mode) |=>
            page_idx == IDX_W'($past(page_idx) + 1'b1));

    // R5: a read step advances the full address modulo the memory size
    a_r5_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && step && rd_mode) |=>
            cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

    // R6, R9: the pointer holds when nothing is requested
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !step) |=> $stable(cur_addr));

endmodule

bind eep_ptr_top eep_ptr_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .step     (step),
    .rd_mode  (rd_mode),
    .cur_addr (cur_addr),
    .page_idx (page_idx)
);

// File: tb/tb_eep_ptr_top.sv
`timescale 1ns/1ps
module tb_eep_ptr_top;

    localparam int AW = 10;
    localparam int IW = 4;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          step = 1'b0;
    logic          rd_mode = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [IW-1:0] page_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    eep_ptr_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .step     (step),
        .rd_mode  (rd_mode),
        .cur_addr (cur_addr),
        .page_idx (page_idx)
    );

    // Vector layout: {ld, addr[9:0], step, rd, expected[9:0]}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 10'h3FD, 1'b0, 1'b0, 10'h3FD},  // R2 load
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h3FE},  // R5 read step
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h3FF},  // R5
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h000},  // R5 R8 top wraps to zero
        {1'b1, 10'h12E, 1'b0, 1'b1, 10'h12E},  // R2
        {1'b0, 10'h000, 1'b1, 1'b0, 10'h12F},  // R4 write step
        {1'b0, 10'h000, 1'b1, 1'b0, 10'h120},  // R4 wrap in page
        {1'b0, 10'h000, 1'b1, 1'b0, 10'h121},  // R4
        {1'b0, 10'h000, 1'b0, 1'b1, 10'h121},  // R6 R9 idle, read mode
        {1'b0, 10'h000, 1'b0, 1'b0, 10'h121},  // R6 R9 idle, write mode
        {1'b1, 10'h0F0, 1'b1, 1'b0, 10'h0F0},  // R3 load + write step
        {1'b1, 10'h0AF, 1'b1, 1'b1, 10'h0AF},  // R3 load + read step
        {1'b0, 10'h000, 1'b1, 1'b1, 10'h0B0},  // R5 carry into row
        {1'b0, 10'h000, 1'b1, 1'b0, 10'h0B1},  // R4
        {1'b1, 10'h3FF, 1'b0, 1'b0, 10'h3FF},  // R2
        {1'b0, 10'h000, 1'b1, 1'b0, 10'h3F0}   // R4 wrap in top page
    };

    // Compare cur_addr and page_idx with the expected address.
    task automatic check(input string req, input logic [AW-1:0] exp);
        total++;
        if (cur_addr !== exp) begin
            bad++;
            $display("FAIL %s cur_addr actual=%h expected=%h", req, cur_addr, exp);
        end
        total++;
        if (page_idx !== exp[IW-1:0]) begin
            bad++;
            $display("FAIL R7 page_idx actual=%h expected=%h", page_idx, exp[IW-1:0]);
        end
    endtask

    // Drive one cycle of stimulus and sample after the edge.
    task automatic cycle(input logic l, input logic [AW-1:0] a,
                         input logic s, input logic r);
        @(negedge clk);
        ld_en = l; ld_addr = a; step = s; rd_mode = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i][22], VEC[i][21:12], VEC[i][11], VEC[i][10]);
            check($sformatf("R2-5 vector %0d", i), VEC[i][9:0]);
        end

        // R6: retention over many idle cycles, then a current-address read continues
        for (int k = 0; k < 5; k++) cycle(1'b0, 10'h155, 1'b0, k[0]);
        check("R6", 10'h3F0);
        cycle(1'b0, 10'h000, 1'b1, 1'b1);
        check("R6", 10'h3F1);

        // R8: full-width read wrap proves a 10-bit address
        cycle(1'b1, 10'h3FF, 1'b0, 1'b1);
        cycle(1'b0, 10'h000, 1'b1, 1'b1);
        check("R8", 10'h000);

        // R1: reset in mid run beats a pending load
        cycle(1'b1, 10'h2A7, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; ld_en = 1'b1; ld_addr = 10'h111;
        @(posedge clk);
        #1;
        check("R1", 10'h000);
        @(negedge clk);
        rst_n = 1'b1; ld_en = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule